// File: doc/BRIEF.md
# Multi-Mode Serial Port

This block is a small serial port that software drives through two byte-wide registers: a control register and a data buffer. The upper two control bits choose one of four modes. Mode 0 is a synchronous shift mode that moves eight bits at a fixed rate of one bit per twelve clocks. Modes 1, 2 and 3 are asynchronous frames of ten or eleven bits. Writing the data buffer starts a transmission. When the frame has been sent, the transmit flag is set. When reception is enabled, a finished incoming frame loads the receive buffer and sets the receive flag.

Each clock cycle counts as one machine tick. Mode 0 and mode 2 take their bit time from the clock. Modes 1 and 3 count pulses on an external overflow input, which usually comes from a neighbouring timer. A double-rate input selects a bit time of 16 or 32 units in modes 1, 2 and 3. Transmit and receive each keep their own bit-time accumulator, so the two directions run independently.

Top module: `mcu_serial_port`

## Requirements
- R1: After reset, the control readback is 0x00, the receive buffer reads 0x00 and the transmit line is high.
- R2: A write to register select 0 stores the whole byte into the control register, and the control readback returns that byte on the next cycle. The fields are: bits [7:6] mode, bit 4 receive enable, bit 1 transmit flag, bit 0 receive flag.
- R3: In mode 0, a buffer write sends the 8 data bits least significant bit first, with no start or stop bit. Each bit lasts exactly 12 clocks.
- R4: In mode 1, a buffer write sends a 10-bit frame in this order: a low start bit, 8 data bits least significant bit first, then a high stop bit. Each bit lasts 16 overflow pulses when double-rate is 1 and 32 pulses when it is 0.
- R5: Modes 2 and 3 send an 11-bit frame: a low start bit, 8 data bits least significant bit first, a high ninth bit, then a high stop bit. In mode 2 a bit lasts 16 or 32 clocks, chosen by double-rate. In mode 3 a bit lasts 16 or 32 overflow pulses.
- R6: The transmit flag (control bit 1) is set on the clock edge that ends the last bit of the frame. In modes 0 and 2 this edge comes exactly frame-length × bit-time clocks after the buffer-write edge. After the frame the line rests high.
- R7: A buffer write during a transmission restarts the frame with the new byte. Both the bit count and the bit-time accumulator are cleared.
- R8: In modes 1 to 3, with receive enable set, a falling edge on the receive line starts a frame. Each bit is sampled at mid-bit. At frame end the data byte goes into the receive buffer and control bit 0 is set.
- R9: In mode 0, reception starts whenever receive enable is 1 and the receive flag is 0. It samples 8 bits, least significant bit first, at mid-bit. No new reception starts while the receive flag is 1.
- R10: When receive enable is 0, an incoming async frame leaves the receive buffer and the receive flag unchanged.
- R11: Hardware never clears the transmit or receive flag; only a control write changes them. If a frame ends in the same cycle as a control write, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each cycle is one machine tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select: 0 control, 1 data buffer |
| wr_data | input | 8 | Write data |
| ovf_pulse | input | 1 | One-cycle overflow pulse used as the bit-rate source in modes 1 and 3 |
| dbl_rate | input | 1 | 1 selects 16 units per bit, 0 selects 32 units (modes 1 to 3) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, high when idle |
| ctrl_rd | output | 8 | Control register readback, including both flags |
| buf_rd | output | 8 | Last received byte |

## Verification
Transmission is tried in all four modes, at both rates, with directed and random bytes. The line is sampled at every bit centre, which catches wrong bit order, missing or extra framing bits, and a wrong ninth bit. In the clock-timed modes the transmit flag is checked one cycle before and exactly at its due edge, which catches a wrong divisor or frame length. The overflow-timed modes are run with a sparse pulse train, which shows that those modes count pulses and not clocks. Reception is driven from the bench in each mode. Negative patterns check the rest of the behaviour: a frame with receive enable off, mode-0 traffic while the receive flag is set, and a second buffer write partway through a frame.

// File: rtl/sp_pkg.sv
package sp_pkg;
    typedef enum logic [1:0] {
        MODE_SHIFT   = 2'd0,
        MODE_ASYNC10 = 2'd1,
        MODE_CLK11   = 2'd2,
        MODE_OVF11   = 2'd3
    } sp_mode_e;

    localparam int FRAME_MAX = 11;

    function automatic logic [3:0] frame_len(input logic [1:0] mode);
        case (mode)
            2'd0:    frame_len = 4'd8;
            2'd1:    frame_len = 4'd10;
            default: frame_len = 4'd11;
        endcase
    endfunction
endpackage

// File: rtl/sp_rate.sv
module sp_rate #(
    parameter int SHIFT_DIV = 12,
    parameter int FAST_DIV  = 16,
    parameter int SLOW_DIV  = 32,
    parameter int CNT_W     = 6
) (
    input  logic [1:0]       mode,
    input  logic             dbl_rate,
    input  logic             ovf_pulse,
    output logic             adv,
    output logic [CNT_W-1:0] div
);
    import sp_pkg::*;

    always_comb begin
        adv = (sp_mode_e'(mode) == MODE_SHIFT || sp_mode_e'(mode) == MODE_CLK11) ? 1'b1 : ovf_pulse;
        if (sp_mode_e'(mode) == MODE_SHIFT)
            div = CNT_W'(SHIFT_DIV);
        else
            div = dbl_rate ? CNT_W'(FAST_DIV) : CNT_W'(SLOW_DIV);
    end
endmodule

// File: rtl/sp_tx.sv
module sp_tx #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       data,
    input  logic [1:0]       mode,
    input  logic             adv,
    input  logic [CNT_W-1:0] div,
    output logic             txd,
    output logic             fin
);
    import sp_pkg::*;

    typedef struct packed {
        logic                 busy;
        logic [CNT_W-1:0]     acc;
        logic [3:0]           cnt;
        logic [FRAME_MAX-1:0] sh;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        fin  = 1'b0;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.acc  = '0;
            st_d.cnt  = '0;
            if (sp_mode_e'(mode) == MODE_SHIFT)
                st_d.sh = {3'b111, data};
            else
                st_d.sh = {2'b11, data, 1'b0};
        end else if (st_q.busy && adv) begin
            if (st_q.acc == div - CNT_W'(1)) begin
                st_d.acc = '0;
                st_d.sh  = {1'b1, st_q.sh[FRAME_MAX-1:1]};
                st_d.cnt = st_q.cnt + 4'd1;
                if (st_q.cnt + 4'd1 == frame_len(mode)) begin
                    st_d.busy = 1'b0;
                    fin       = 1'b1;
                end
            end else begin
                st_d.acc = st_q.acc + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy <= 1'b0;
            st_q.acc  <= '0;
            st_q.cnt  <= '0;
            st_q.sh   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign txd = st_q.sh[0];
endmodule

// File: rtl/sp_rx.sv
module sp_rx #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    input  logic [1:0]       mode,
    input  logic             ren,
    input  logic             flag,
    input  logic             adv,
    input  logic [CNT_W-1:0] div,
    output logic             fin,
    output logic [7:0]       data
);
    import sp_pkg::*;

    typedef struct packed {
        logic             busy;
        logic             prev;
        logic [CNT_W-1:0] acc;
        logic [3:0]       cnt;
        logic [7:0]       dat;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic      is_shift;
    logic      go;

    always_comb begin
        st_d      = st_q;
        st_d.prev = rxd;
        fin       = 1'b0;
        is_shift  = (sp_mode_e'(mode) == MODE_SHIFT);
        go        = ren && (is_shift ? !flag : (st_q.prev && !rxd));
        if (!st_q.busy) begin
            if (go) begin
                st_d.busy = 1'b1;
                st_d.acc  = '0;
                st_d.cnt  = '0;
            end
        end else if (adv) begin
            if (st_q.acc == (div >> 1)) begin
                if (is_shift)
                    st_d.dat[st_q.cnt[2:0]] = rxd;
                else if (st_q.cnt >= 4'd1 && st_q.cnt <= 4'd8)
                    st_d.dat[3'(st_q.cnt - 4'd1)] = rxd;
            end
            if (st_q.acc == div - CNT_W'(1)) begin
                st_d.acc = '0;
                st_d.cnt = st_q.cnt + 4'd1;
                if (st_q.cnt + 4'd1 == frame_len(mode)) begin
                    st_d.busy = 1'b0;
                    fin       = 1'b1;
                end
            end else begin
                st_d.acc = st_q.acc + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy <= 1'b0;
            st_q.prev <= 1'b1;
            st_q.acc  <= '0;
            st_q.cnt  <= '0;
            st_q.dat  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data = st_q.dat;
endmodule

// File: rtl/mcu_serial_port.sv
module mcu_serial_port #(
    parameter int SHIFT_DIV = 12,
    parameter int FAST_DIV  = 16,
    parameter int SLOW_DIV  = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic       ovf_pulse,
    input  logic       dbl_rate,
    input  logic       rxd,
    output logic       txd,
    output logic [7:0] ctrl_rd,
    output logic [7:0] buf_rd
);
    localparam int CNT_W = $clog2(SLOW_DIV + 1);

    typedef struct packed {
        logic [7:0] ctrl;
        logic [7:0] rbuf;
    } top_state_t;

    top_state_t st_d, st_q;

    logic             adv;
    logic [CNT_W-1:0] div;
    logic             tx_fin, rx_fin, tx_start;
    logic [7:0]       rx_data;

    assign tx_start = wr_en && wr_addr;

    sp_rate #(
        .SHIFT_DIV(SHIFT_DIV), .FAST_DIV(FAST_DIV),
        .SLOW_DIV(SLOW_DIV), .CNT_W(CNT_W)
    ) u_rate (
        .mode(st_q.ctrl[7:6]), .dbl_rate(dbl_rate), .ovf_pulse(ovf_pulse),
        .adv(adv), .div(div)
    );

    sp_tx #(.CNT_W(CNT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .data(wr_data),
        .mode(st_q.ctrl[7:6]), .adv(adv), .div(div),
        .txd(txd), .fin(tx_fin)
    );

    sp_rx #(.CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .mode(st_q.ctrl[7:6]),
        .ren(st_q.ctrl[4]), .flag(st_q.ctrl[0]), .adv(adv), .div(div),
        .fin(rx_fin), .data(rx_data)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en && !wr_addr)
            st_d.ctrl = wr_data;
        if (tx_fin)
            st_d.ctrl[1] = 1'b1;
        if (rx_fin) begin
            st_d.ctrl[0] = 1'b1;
            st_d.rbuf    = rx_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign ctrl_rd = st_q.ctrl;
    assign buf_rd  = st_q.rbuf;
endmodule

// File: rtl/sp_checker.sv
module sp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_wr,
    input logic       buf_wr,
    input logic [1:0] mode_wr,
    input logic [1:0] mode_rd,
    input logic [1:0] flags_rd,
    input logic [7:0] buf_rd,
    input logic       txd
);
    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> mode_rd == $past(mode_wr));  // R2

    AST_RX_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        flags_rd[0] && !ctrl_wr |=> flags_rd[0]);  // R11

    AST_TX_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        flags_rd[1] && !ctrl_wr |=> flags_rd[1]);  // R11

    AST_BUF_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(buf_rd) |-> flags_rd[0]);  // R8

    AST_LINE_IDLE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_rd[1]) && !$past(ctrl_wr) && !$past(buf_wr) |-> txd);  // R6
endmodule

bind mcu_serial_port sp_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(wr_en && !wr_addr), .buf_wr(wr_en && wr_addr),
    .mode_wr(wr_data[7:6]), .mode_rd(ctrl_rd[7:6]), .flags_rd(ctrl_rd[1:0]),
    .buf_rd(buf_rd), .txd(txd)
);

// File: tb/mcu_serial_port_bench.sv
module mcu_serial_port_bench;
    localparam int K = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ovf_pulse = 1'b0;
    logic       dbl_rate = 1'b0;
    logic       rxd = 1'b1;
    logic       txd;
    logic [7:0] ctrl_rd, buf_rd;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mcu_serial_port u_mcu_serial_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ovf_pulse(ovf_pulse), .dbl_rate(dbl_rate),
        .rxd(rxd), .txd(txd), .ctrl_rd(ctrl_rd), .buf_rd(buf_rd)
    );

    initial begin
        forever begin
            repeat (K - 1) @(negedge clk);
            ovf_pulse = 1'b1;
            @(negedge clk);
            ovf_pulse = 1'b0;
        end
    end

    function automatic int frame_bits(input logic [1:0] md);
        return (md == 2'd0) ? 8 : (md == 2'd1) ? 10 : 11;
    endfunction

    function automatic int bit_cycles(input logic [1:0] md, input logic db);
        int u;
        u = db ? 16 : 32;
        if (md == 2'd0) return 12;
        if (md == 2'd2) return u;
        return u * K;
    endfunction

    function automatic logic exp_bit(input logic [1:0] md, input logic [7:0] b, input int i);
        if (md == 2'd0) return b[i];
        if (i == 0) return 1'b0;
        if (i <= 8) return b[i-1];
        return 1'b1;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_tx(input logic [1:0] md, input logic db, input logic [7:0] b);
        int bt, len, slack;
        string tag;
        bt = bit_cycles(md, db);
        len = frame_bits(md);
        slack = md[0] ? K : 0;
        tag = (md == 2'd0) ? "R3" : (md == 2'd1) ? "R4" : "R5";
        dbl_rate = db;
        wr_reg(1'b0, {md, 6'b0});
        wr_reg(1'b1, b);
        for (int m = 1; m <= len * bt; m++) begin
            @(negedge clk);
            if (m >= bt / 2 && (m - bt / 2) % bt == 0 && (m - bt / 2) / bt < len)
                check(tag, {7'b0, txd}, {7'b0, exp_bit(md, b, (m - bt / 2) / bt)});
            if (m == len * bt - 1 - slack)
                check("R6 flag early", {7'b0, ctrl_rd[1]}, 8'd0);
        end
        check("R6 flag due", {7'b0, ctrl_rd[1]}, 8'd1);
        check("R6 idle line", {7'b0, txd}, 8'd1);
    endtask

    task automatic run_rx(input logic [1:0] md, input logic db, input logic [7:0] b);
        int bt, len;
        bt = bit_cycles(md, db);
        len = frame_bits(md);
        dbl_rate = db;
        if (md == 2'd0) begin
            rxd = b[0];
            wr_reg(1'b0, 8'h10);
            @(negedge clk);
            for (int i = 0; i < 8; i++) begin
                rxd = b[i];
                repeat (12) @(negedge clk);
            end
            repeat (4) @(negedge clk);
            check("R9 flag", {7'b0, ctrl_rd[0]}, 8'd1);
            check("R9 data", buf_rd, b);
        end else begin
            rxd = 1'b1;
            wr_reg(1'b0, {md, 6'b010000});
            repeat (4) @(negedge clk);
            for (int i = 0; i < len; i++) begin
                rxd = exp_bit(md, b, i);
                repeat (bt) @(negedge clk);
            end
            rxd = 1'b1;
            repeat (bt) @(negedge clk);
            check("R8 flag", {7'b0, ctrl_rd[0]}, 8'd1);
            check("R8 data", buf_rd, b);
        end
        rxd = 1'b1;
    endtask

    task automatic finish_run;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R1 ctrl", ctrl_rd, 8'h00);
        check("R1 buf", buf_rd, 8'h00);
        check("R1 txd", {7'b0, txd}, 8'd1);
        rst_n = 1'b1;
        @(negedge clk);

        wr_reg(1'b0, 8'hB5);
        check("R2 readback", ctrl_rd, 8'hB5);
        wr_reg(1'b0, 8'h00);
        check("R2 cleared", ctrl_rd, 8'h00);

        run_tx(2'd0, 1'b0, 8'hA5);
        run_tx(2'd0, 1'b1, 8'h01);
        run_tx(2'd1, 1'b1, 8'h3C);
        run_tx(2'd2, 1'b1, 8'hFF);
        run_tx(2'd2, 1'b0, 8'h00);
        run_tx(2'd3, 1'b1, 8'h96);

        // R7: second buffer write restarts the frame
        wr_reg(1'b0, 8'h00);
        wr_reg(1'b1, 8'h55);
        repeat (30) @(negedge clk);
        wr_reg(1'b1, 8'h0F);
        for (int m = 1; m <= 96; m++) begin
            @(negedge clk);
            if (m == 6) check("R7 new first bit", {7'b0, txd}, 8'd1);
            if (m == 66) check("R7 no early flag", {7'b0, ctrl_rd[1]}, 8'd0);
            if (m == 95) check("R7 flag edge-1", {7'b0, ctrl_rd[1]}, 8'd0);
            if (m == 54) check("R7 bit4", {7'b0, txd}, 8'd0);
        end
        check("R7 flag due", {7'b0, ctrl_rd[1]}, 8'd1);

        // R11: flag persists until software write
        repeat (200) @(negedge clk);
        check("R11 tx flag held", {7'b0, ctrl_rd[1]}, 8'd1);
        wr_reg(1'b0, 8'h00);
        check("R11 tx flag cleared", {7'b0, ctrl_rd[1]}, 8'd0);

        run_rx(2'd1, 1'b1, 8'hC3);
        repeat (200) @(negedge clk);
        check("R11 rx flag held", {7'b0, ctrl_rd[0]}, 8'd1);
        run_rx(2'd2, 1'b0, 8'h5A);
        run_rx(2'd3, 1'b1, 8'h81);

        // R10: receiver disabled
        wr_reg(1'b0, 8'h40);
        dbl_rate = 1'b1;
        for (int i = 0; i < 10; i++) begin
            rxd = exp_bit(2'd1, 8'h27, i);
            repeat (16 * K) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (60) @(negedge clk);
        check("R10 flag", {7'b0, ctrl_rd[0]}, 8'd0);
        check("R10 buf", buf_rd, 8'h81);

        // R9: mode 0 reception and no restart while flag set
        run_rx(2'd0, 1'b0, 8'h6B);
        for (int i = 0; i < 120; i++) begin
            rxd = i[2];
            @(negedge clk);
        end
        rxd = 1'b1;
        check("R9 held buf", buf_rd, 8'h6B);

        for (int k = 0; k < 6; k++)
            run_tx(2'($urandom % 4), 1'($urandom % 2), 8'($urandom));
        for (int k = 0; k < 3; k++)
            run_rx(2'(1 + $urandom % 3), 1'($urandom % 2), 8'($urandom));

        done = 1'b1;
        finish_run();
    end
endmodule